// File: doc/BRIEF.md
# Acquire/Release Cache-Walk Sequencer

This block enforces memory ordering in front of a small L1 data cache. Each incoming request carries three flags: acquire, release and kernel-boundary. When a request needs ordering, the block steps through every line index of the cache and sends one command per line on a command stream. An acquire sends an invalidate for each line. A release sends a flush (write back dirty data) for each line. A request flagged with both sends the full invalidate pass and then the full flush pass.

The block keeps two counts: flushes not yet acknowledged and invalidates not yet acknowledged. The cache returns one completion pulse per command. While any flush is outstanding, the issue-enable output is low, so the surrounding issue logic holds back ordinary traffic.

A kernel-end request is a kernel request flagged release. Its context number is stored in a small record. When the flush count drains to zero, every stored context is reported, oldest first, on a completion stream. A kernel-begin request is a kernel request flagged acquire. It invalidates the cache, but while flushes are pending it does so only if no invalidates are still outstanding. Invalidate completions are counted, but nothing waits on them.

Stream rules: every stream moves one item on a clock edge where valid and ready are both high. The request port may lower `req_ready` depending on the flags it is offered. A producer that sees ready low may withdraw or change its request. Command and completion items hold stable while their ready input is low.

Top module: `ordering_walker`

## Requirements
- R1: A request flagged release but not acquire, with no kernel flag, produces NLINES commands with `cmd_flush`=1 on lines 0, 1, …, NLINES-1 in ascending order. `wb_pending` rises by one per accepted command.
- R2: A request flagged acquire but not release produces NLINES commands with `cmd_flush`=0 on ascending lines. `inv_pending` rises by one per accepted command. With no flush pending, this holds whether or not the kernel flag is set.
- R3: A non-kernel request flagged both acquire and release produces the full invalidate pass, then the full flush pass (2·NLINES commands in total).
- R4: `issue_en` is high exactly when `wb_pending` is zero.
- R5: Each `wb_done` pulse lowers `wb_pending` by one. Once the count is zero and no pass is running, every stored kernel-end context appears on `kend_ctx` in arrival order, one per handshake.
- R6: A kernel-end request arriving with no flush pending is stored and starts a flush pass only; the acquire flag is ignored in this case. It is reported only after the flushes drain.
- R7: While flushes are pending, a kernel-begin request starts an invalidate pass only if `inv_pending` is zero; otherwise it is accepted with no commands. A kernel-end request is stored with no commands.
- R8: `inv_done` lowers `inv_pending` by one and has no effect on `issue_en` or on kernel-end reporting.
- R9: The block sends at most one command per cycle. While `cmd_ready` is low, `cmd_valid`, `cmd_flush` and `cmd_line` hold.
- R10: `req_ready` is low in any of these cases:
  - a pass is running;
  - stored contexts are being reported;
  - the request would be stored and the record (KEND_DEPTH entries) is full;
  - the request would start a pass whose counter already exceeds NLINES.
- R11: A completion pulse that arrives while its counter is zero raises `cnt_underflow` for that cycle and leaves the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_acq | input | 1 | Acquire flag |
| req_rel | input | 1 | Release flag |
| req_kern | input | 1 | Kernel-boundary flag |
| req_ctx | input | CTX_W | Context number of the request |
| cmd_valid | output | 1 | Per-line command valid |
| cmd_ready | input | 1 | Cache accepts the command |
| cmd_flush | output | 1 | 1 = flush line, 0 = invalidate line |
| cmd_line | output | LINE_W | Line index of the command |
| wb_done | input | 1 | One flush acknowledged |
| inv_done | input | 1 | One invalidate acknowledged |
| wb_pending | output | CNT_W | Outstanding flush count |
| inv_pending | output | CNT_W | Outstanding invalidate count |
| issue_en | output | 1 | Ordinary issue allowed |
| kend_valid | output | 1 | A kernel-end completion is offered |
| kend_ready | input | 1 | Consumer takes the completion |
| kend_ctx | output | CTX_W | Context of the completed kernel-end |
| cnt_underflow | output | 1 | Completion pulse arrived on a zero counter |

## Verification
The hardest state to reach is a full kernel-end record while flushes are pending, together with an invalidate count that is already nonzero. Only that state shows both the skipped kernel-begin pass and the back-pressure on a full record. The bench gets there with one plain release that leaves flushes pending, then one kernel-begin, a second kernel-begin and two kernel-ends, all without acknowledging anything. It then releases the flushes one pulse at a time with the completion consumer stalled. The per-flag behaviour with nothing pending is covered by a sweep over all eight flag combinations, each fully drained before the next.

// File: rtl/ordwalk_pkg.sv
package ordwalk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INV,
    ST_FLUSH
  } walk_st_e;

  typedef struct packed {
    logic do_inv;
    logic do_flush;
    logic record;
  } walk_plan_t;

  // Ordering decision for one request, given which counters are busy.
  function automatic walk_plan_t decide(input logic acq, input logic rel,
                                        input logic kern, input logic wb_busy,
                                        input logic inv_busy);
    walk_plan_t p;
    p = '0;
    if (wb_busy && kern) begin
      p.do_inv   = acq && !inv_busy;
      p.do_flush = 1'b0;
      p.record   = rel;
    end else if (kern && rel) begin
      p.do_inv   = 1'b0;
      p.do_flush = 1'b1;
      p.record   = 1'b1;
    end else begin
      p.do_inv   = acq;
      p.do_flush = rel;
      p.record   = 1'b0;
    end
    return p;
  endfunction

endpackage

// File: rtl/ow_line_walker.sv
module ow_line_walker #(
  parameter int NLINES = 64,
  parameter int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  output logic [LINE_W-1:0] line,
  output logic              last
);

  localparam logic [LINE_W-1:0] LAST_IDX = LINE_W'(NLINES - 1);

  generate
    if (NLINES == 1) begin : g_single
      assign line = '0;
    end else begin : g_multi
      logic [LINE_W-1:0] idx;
      always_ff @(posedge clk) begin
        if (!rst_n || start) idx <= '0;
        else if (step) idx <= (idx == LAST_IDX) ? '0 : idx + LINE_W'(1);
      end
      assign line = idx;
    end
  endgenerate

  assign last = (line == LAST_IDX);

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step && !start && last |=> line == '0);

endmodule

// File: rtl/ow_pend_counter.sv
module ow_pend_counter #(
  parameter int MAXV  = 128,
  parameter int CNT_W = $clog2(MAXV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             zero,
  output logic             underflow
);

  assign zero      = (cnt == '0);
  assign underflow = dec && !inc && zero;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (inc && !dec) cnt <= cnt + CNT_W'(1);
    else if (dec && !inc && !zero) cnt <= cnt - CNT_W'(1);
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !dec |-> cnt < CNT_W'(MAXV));

  p_under_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> cnt == '0);

  p_dec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !inc && !zero |=> cnt == $past(cnt) - CNT_W'(1));

endmodule

// File: rtl/ow_ctx_fifo.sv
module ow_ctx_fifo #(
  parameter int DEPTH = 4,
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CTX_W-1:0] push_ctx,
  input  logic             pop,
  output logic [CTX_W-1:0] head,
  output logic             empty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [CTX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [OCC_W-1:0] occ;

  assign empty = (occ == '0);
  assign full  = (occ == OCC_W'(DEPTH));
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_ctx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (push) wp <= (wp == PTR_LAST) ? '0 : wp + PTR_W'(1);
      if (pop)  rp <= (rp == PTR_LAST) ? '0 : rp + PTR_W'(1);
      if (push && !pop) occ <= occ + OCC_W'(1);
      else if (pop && !push) occ <= occ - OCC_W'(1);
    end
  end

  p_push_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  p_pop_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/ordering_walker.sv
module ordering_walker
  import ordwalk_pkg::*;
#(
  parameter int NLINES     = 64,
  parameter int KEND_DEPTH = 4,
  parameter int CTX_W      = 8,
  parameter int LINE_W     = (NLINES > 1) ? $clog2(NLINES) : 1,
  parameter int CNT_W      = $clog2(2 * NLINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_acq,
  input  logic              req_rel,
  input  logic              req_kern,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_flush,
  output logic [LINE_W-1:0] cmd_line,
  input  logic              wb_done,
  input  logic              inv_done,
  output logic [CNT_W-1:0]  wb_pending,
  output logic [CNT_W-1:0]  inv_pending,
  output logic              issue_en,
  output logic              kend_valid,
  input  logic              kend_ready,
  output logic [CTX_W-1:0]  kend_ctx,
  output logic              cnt_underflow
);

  localparam int MAXV = 2 * NLINES;
  localparam logic [CNT_W-1:0] HEADROOM = CNT_W'(NLINES);

  walk_st_e   st;
  logic       then_flush;
  walk_plan_t plan;
  logic       idle, accept, cmd_fire, line_last;
  logic       wb_zero, inv_zero, wb_under, inv_under;
  logic       rec_empty, rec_full, draining, room_ok;

  assign idle = (st == ST_IDLE);
  assign plan = decide(req_acq, req_rel, req_kern, !wb_zero, !inv_zero);

  assign room_ok = (!plan.do_inv   || inv_pending <= HEADROOM) &&
                   (!plan.do_flush || wb_pending  <= HEADROOM) &&
                   (!plan.record   || !rec_full);
  assign draining  = idle && wb_zero && !rec_empty;
  assign req_ready = idle && !draining && room_ok;
  assign accept    = req_valid && req_ready;

  assign cmd_valid = !idle;
  assign cmd_flush = (st == ST_FLUSH);
  assign cmd_fire  = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      then_flush <= 1'b0;
    end else if (accept) begin
      if (plan.do_inv) begin
        st         <= ST_INV;
        then_flush <= plan.do_flush;
      end else if (plan.do_flush) begin
        st <= ST_FLUSH;
      end
    end else if (cmd_fire && line_last) begin
      if (st == ST_INV && then_flush) begin
        st         <= ST_FLUSH;
        then_flush <= 1'b0;
      end else begin
        st <= ST_IDLE;
      end
    end
  end

  ow_line_walker #(.NLINES(NLINES), .LINE_W(LINE_W)) u_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .step (cmd_fire),
    .line (cmd_line),
    .last (line_last)
  );

  ow_pend_counter #(.MAXV(MAXV), .CNT_W(CNT_W)) u_wb_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (cmd_fire && cmd_flush),
    .dec      (wb_done),
    .cnt      (wb_pending),
    .zero     (wb_zero),
    .underflow(wb_under)
  );

  ow_pend_counter #(.MAXV(MAXV), .CNT_W(CNT_W)) u_inv_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (cmd_fire && !cmd_flush),
    .dec      (inv_done),
    .cnt      (inv_pending),
    .zero     (inv_zero),
    .underflow(inv_under)
  );

  ow_ctx_fifo #(.DEPTH(KEND_DEPTH), .CTX_W(CTX_W)) u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (accept && plan.record),
    .push_ctx(req_ctx),
    .pop     (kend_valid && kend_ready),
    .head    (kend_ctx),
    .empty   (rec_empty),
    .full    (rec_full)
  );

  assign kend_valid    = draining;
  assign issue_en      = wb_zero;
  assign cnt_underflow = wb_under || inv_under;

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_line) && $stable(cmd_flush));

  p_first_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> cmd_line == '0);

  p_line_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !line_last |=> cmd_valid && cmd_line == $past(cmd_line) + LINE_W'(1));

  p_walk_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  p_kend_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kend_valid |-> issue_en && !cmd_valid);

endmodule

// File: tb/sim_ordering_walker.sv
`timescale 1ns/1ps
module sim_ordering_walker;

  localparam int NL = 4;
  localparam int KD = 2;
  localparam int CW = 4;
  localparam int LW = 2;
  localparam int CNW = $clog2(2 * NL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_acq = 1'b0, req_rel = 1'b0, req_kern = 1'b0;
  logic [CW-1:0] req_ctx = '0;
  logic cmd_ready = 1'b1, wb_done = 1'b0, inv_done = 1'b0, kend_ready = 1'b1;
  logic req_ready, cmd_valid, cmd_flush, issue_en, kend_valid, cnt_underflow;
  logic [LW-1:0] cmd_line;
  logic [CNW-1:0] wb_pending, inv_pending;
  logic [CW-1:0] kend_ctx;

  always #5 clk = ~clk;

  ordering_walker #(.NLINES(NL), .KEND_DEPTH(KD), .CTX_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_acq(req_acq), .req_rel(req_rel), .req_kern(req_kern), .req_ctx(req_ctx),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_flush(cmd_flush),
    .cmd_line(cmd_line), .wb_done(wb_done), .inv_done(inv_done),
    .wb_pending(wb_pending), .inv_pending(inv_pending), .issue_en(issue_en),
    .kend_valid(kend_valid), .kend_ready(kend_ready), .kend_ctx(kend_ctx),
    .cnt_underflow(cnt_underflow)
  );

  int n_chk = 0, n_err = 0;
  int log_n = 0, kend_n = 0, uf_n = 0;
  int log_fl [64];
  int log_ln [64];
  int kend_log [16];
  int mwb = 0, minv = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (cmd_valid && cmd_ready && log_n < 64) begin
      log_fl[log_n] = int'(cmd_flush);
      log_ln[log_n] = int'(cmd_line);
      log_n++;
    end
    if (kend_valid && kend_ready && kend_n < 16) begin
      kend_log[kend_n] = int'(kend_ctx);
      kend_n++;
    end
    if (cnt_underflow) uf_n++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Expected ordering action from the requirements: {inv, flush, record}
  function automatic logic [2:0] expect_plan(bit a, bit r, bit k, int wb, int inv);
    if (wb > 0 && k) return {a && inv == 0, 1'b0, r};
    if (k && r)      return 3'b011;
    return {a, r, 1'b0};
  endfunction

  task automatic send(bit a, bit r, bit k, int ctx);
    @(posedge clk); #1;
    req_valid = 1'b1; req_acq = a; req_rel = r; req_kern = k; req_ctx = CW'(ctx);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; req_acq = 1'b0; req_rel = 1'b0; req_kern = 1'b0;
  endtask

  task automatic expect_blocked(bit a, bit r, bit k, string tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_acq = a; req_rel = r; req_kern = k;
    @(negedge clk);
    chk(req_ready == 1'b0, tag, int'(req_ready), 0);
    @(posedge clk); #1;
    req_valid = 1'b0; req_acq = 1'b0; req_rel = 1'b0; req_kern = 1'b0;
  endtask

  task automatic wait_walk();
    do @(negedge clk); while (cmd_valid);
  endtask

  task automatic pulse(bit wb, int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (wb) wb_done = 1'b1; else inv_done = 1'b1;
      @(posedge clk); #1;
      wb_done = 1'b0; inv_done = 1'b0;
    end
    @(negedge clk);
  endtask

  // Compare logged commands from position base against an expected pass sequence
  task automatic chk_cmds(int base, bit inv, bit fl, string tag);
    int k;
    k = base;
    chk(log_n - base == NL * (int'(inv) + int'(fl)), tag, log_n - base,
        NL * (int'(inv) + int'(fl)));
    if (log_n - base == NL * (int'(inv) + int'(fl))) begin
      if (inv) for (int i = 0; i < NL; i++) begin
        chk(log_fl[k] == 0 && log_ln[k] == i, tag, log_fl[k] * 100 + log_ln[k], i);
        k++;
      end
      if (fl) for (int i = 0; i < NL; i++) begin
        chk(log_fl[k] == 1 && log_ln[k] == i, tag, log_fl[k] * 100 + log_ln[k], 100 + i);
        k++;
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [2:0] p;
    string tg;
    int base, kb, ub;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cmd_valid && issue_en && !kend_valid, "reset R4", 0, 0);
    chk(wb_pending == 0 && inv_pending == 0, "reset R5", int'(wb_pending), 0);

    // Sweep every flag combination with nothing pending (R1 R2 R3 R6)
    for (int c = 0; c < 8; c++) begin
      p = expect_plan(c[0], c[1], c[2], 0, 0);
      tg = p[0] ? "R6" : (p[2] && p[1]) ? "R3" : p[1] ? "R1" : "R2";
      base = log_n; kb = kend_n;
      send(c[0], c[1], c[2], c + 1);
      wait_walk();
      chk_cmds(base, p[2], p[1], tg);
      mwb = p[1] ? NL : 0; minv = p[2] ? NL : 0;
      chk(int'(wb_pending) == mwb, {tg, " R1 wb count"}, int'(wb_pending), mwb);
      chk(int'(inv_pending) == minv, {tg, " R2 inv count"}, int'(inv_pending), minv);
      chk(issue_en == (mwb == 0), "R4 issue gate", int'(issue_en), int'(mwb == 0));
      pulse(1'b0, minv);
      chk(kend_n == kb, "R8 inv drain no report", kend_n - kb, 0);
      chk(issue_en == (mwb == 0), "R8 inv drain issue", int'(issue_en), int'(mwb == 0));
      pulse(1'b1, mwb);
      repeat (3) @(negedge clk);
      chk(issue_en == 1'b1, "R4 issue back", int'(issue_en), 1);
      chk(kend_n - kb == int'(p[0]), "R6 kend report", kend_n - kb, int'(p[0]));
      if (p[0] && kend_n > kb)
        chk(kend_log[kb] == c + 1, "R6 kend ctx", kend_log[kb], c + 1);
    end

    // Flushes pending: kernel requests (R7 R10 R5)
    base = log_n; kb = kend_n;
    send(0, 1, 0, 0);
    wait_walk();
    chk_cmds(base, 0, 1, "R1");
    base = log_n;
    send(1, 0, 1, 0);
    wait_walk();
    chk_cmds(base, 1, 0, "R7 kbegin inv");
    base = log_n;
    send(1, 0, 1, 0);
    wait_walk();
    chk(log_n == base, "R7 kbegin skipped", log_n - base, 0);
    send(0, 1, 1, 5);
    send(0, 1, 1, 9);
    wait_walk();
    chk(log_n == base, "R7 kend no walk", log_n - base, 0);
    expect_blocked(0, 1, 1, "R10 record full");
    chk(int'(inv_pending) == NL, "R7 inv count", int'(inv_pending), NL);
    pulse(1'b1, NL - 1);
    chk(kend_n == kb && issue_en == 1'b0, "R5 no early report", kend_n - kb, 0);
    kend_ready = 1'b0;
    pulse(1'b1, 1);
    @(negedge clk);
    chk(kend_valid && int'(kend_ctx) == 5, "R5 first ctx", int'(kend_ctx), 5);
    chk(req_ready == 1'b0, "R10 drain blocks", int'(req_ready), 0);
    @(negedge clk);
    chk(kend_valid && int'(kend_ctx) == 5, "R5 hold ctx", int'(kend_ctx), 5);
    @(posedge clk); #1 kend_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(kend_n - kb == 2, "R5 report count", kend_n - kb, 2);
    if (kend_n - kb == 2) begin
      chk(kend_log[kb] == 5, "R5 order 0", kend_log[kb], 5);
      chk(kend_log[kb + 1] == 9, "R5 order 1", kend_log[kb + 1], 9);
    end
    pulse(1'b0, NL);
    chk(inv_pending == 0, "R8 inv drained", int'(inv_pending), 0);

    // Command back-pressure (R9 R10)
    base = log_n;
    @(posedge clk); #1 cmd_ready = 1'b0;
    send(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cmd_valid && cmd_line == 0 && cmd_flush, "R9 hold", int'(cmd_line), 0);
      chk(req_ready == 1'b0, "R10 walk blocks", int'(req_ready), 0);
    end
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1 cmd_ready = i[0];
    end
    @(posedge clk); #1 cmd_ready = 1'b1;
    wait_walk();
    chk_cmds(base, 0, 1, "R9 order");

    // Counter headroom (R10)
    send(0, 1, 0, 0);
    wait_walk();
    chk(int'(wb_pending) == 2 * NL, "R10 two passes", int'(wb_pending), 2 * NL);
    expect_blocked(0, 1, 0, "R10 headroom");
    pulse(1'b1, 2 * NL);
    chk(wb_pending == 0 && issue_en, "R4 drained", int'(wb_pending), 0);

    // Underflow (R11)
    ub = uf_n;
    pulse(1'b1, 1);
    chk(uf_n - ub == 1, "R11 wb underflow", uf_n - ub, 1);
    chk(wb_pending == 0 && issue_en, "R11 wb stays zero", int'(wb_pending), 0);
    pulse(1'b0, 1);
    chk(uf_n - ub == 2, "R11 inv underflow", uf_n - ub, 2);
    chk(inv_pending == 0, "R11 inv stays zero", int'(inv_pending), 0);

    finish_run();
  end

endmodule